// File: doc/BRIEF.md
# Partial-Word Byte Store Aligner

This block turns a partial-word store request into exactly one aligned, big-endian word write with byte enables. A request carries a byte address, a 32-bit register value and a fill mode. In tail-fill mode the value's low-order bytes are written from the addressed byte to the end of the word. In head-fill mode the value's high-order bytes are written from the start of the word up to the byte just before the addressed byte. A head-fill request at offset zero writes no byte. It still issues one probe-only cycle, so that a downstream permission checker sees the access.

Memory is big-endian: byte offset 0 is the most significant byte of the word. Every request, the three-byte cases included, leaves the block as a single write beat, so a store that touches three bytes can never be observed half done. Requests enter through a valid/ready handshake. Writes leave through a one-entry registered valid/ready stage.

Top module: `bytestore_align`

## Requirements
- R1: After reset `wr_valid` is 0 and `req_ready` is 1.
- R2: `wr_addr` equals the request address with its two low bits cleared.
- R3: Tail-fill (`req_head`=0) at offset 0 enables all four bytes (`wr_be`=4'b1111). `wr_be` bit 3 maps to offset 0 and bit 0 to offset 3.
- R4: Tail-fill at offset k>0 enables offsets k..3: offset 1 gives 4'b0111, offset 2 gives 4'b0011, offset 3 gives 4'b0001.
- R5: Head-fill (`req_head`=1) at offset k>0 enables offsets 0..k-1: offset 1 gives 4'b1000, offset 2 gives 4'b1100, offset 3 gives 4'b1110.
- R6: Head-fill at offset 0 produces one beat with `wr_probe`=1 and `wr_be`=4'b0000, which completes through a single handshake.
- R7: Each enabled lane of `wr_data` carries the value byte in the same bit position (offset 0 = value bits 31:24). Disabled lanes are zero.
- R8: Every accepted request yields exactly one write beat, so three-byte stores are never split.
- R9: `req_ready` = !wr_valid || wr_ready. A beat that is held (`wr_valid`=1, `wr_ready`=0) keeps all of its outputs stable until it is taken.
- R10: `wr_probe` is 0 on every beat whose `wr_be` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_head | input | 1 | 0 = tail-fill, 1 = head-fill |
| req_addr | input | ADDR_W | Byte address |
| req_value | input | 8*LANES | Register value |
| wr_valid | output | 1 | Write beat present |
| wr_ready | input | 1 | Write beat taken this cycle when high with wr_valid |
| wr_addr | output | ADDR_W | Word-aligned address |
| wr_data | output | 8*LANES | Lane-steered data |
| wr_be | output | LANES | Byte enables, MSB = offset 0 |
| wr_probe | output | 1 | Probe-only beat |

## Verification
The bench builds the block with a 12-bit address and the default four lanes. The narrow address lets random addresses revisit every offset and both modes many times within a short run. Four lanes give all eight offset/mode combinations, including the two three-byte masks and the zero-byte probe. Randomly throttled `wr_ready` exercises back-pressure against a queue-based reference model.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
  typedef enum logic {FILL_TAIL = 1'b0, FILL_HEAD = 1'b1} fill_mode_e;
endpackage

// File: rtl/bsa_lane_mask.sv
module bsa_lane_mask #(
  parameter int LANES = 4,
  localparam int OFS_W = $clog2(LANES)
) (
  input  bsa_pkg::fill_mode_e mode,
  input  logic [OFS_W-1:0]    ofs,
  output logic [LANES-1:0]    be,
  output logic                probe
);
  // Lane i is byte offset i; big-endian so it drives enable bit LANES-1-i.
  function automatic logic lane_on(bsa_pkg::fill_mode_e m, int lane, int o);
    if (m == bsa_pkg::FILL_TAIL) return lane >= o;
    else                         return lane < o;
  endfunction

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign be[LANES-1-i] = lane_on(mode, i, int'(ofs));
  end

  assign probe = (mode == bsa_pkg::FILL_HEAD) && (ofs == '0);

  // R10: a probe never coincides with an enabled byte
  always_comb begin
    a_probe_empty_r10: assert (!(probe && (be != '0)));
  end
endmodule

// File: rtl/bsa_lane_steer.sv
module bsa_lane_steer #(
  parameter int LANES = 4,
  localparam int DW = 8 * LANES
) (
  input  logic [DW-1:0]    value,
  input  logic [LANES-1:0] be,
  output logic [DW-1:0]    data
);
  for (genvar b = 0; b < LANES; b++) begin : g_byte
    assign data[8*b +: 8] = be[b] ? value[8*b +: 8] : 8'h00;
  end
endmodule

// File: rtl/bsa_out_reg.sv
module bsa_out_reg #(
  parameter int ADDR_W = 32,
  parameter int LANES  = 4,
  localparam int DW = 8 * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] n_addr,
  input  logic [DW-1:0]     n_data,
  input  logic [LANES-1:0]  n_be,
  input  logic              n_probe,
  output logic              q_valid,
  input  logic              q_ready,
  output logic [ADDR_W-1:0] q_addr,
  output logic [DW-1:0]     q_data,
  output logic [LANES-1:0]  q_be,
  output logic              q_probe
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_addr  <= '0;
      q_data  <= '0;
      q_be    <= '0;
      q_probe <= 1'b0;
    end else begin
      if (load) begin
        q_valid <= 1'b1;
        q_addr  <= n_addr;
        q_data  <= n_data;
        q_be    <= n_be;
        q_probe <= n_probe;
      end else if (q_ready) begin
        q_valid <= 1'b0;
      end
    end
  end

  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid && !q_ready |=> q_valid && $stable(q_addr) && $stable(q_data)
                            && $stable(q_be) && $stable(q_probe));

  p_load_shows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> q_valid);
endmodule

// File: rtl/bytestore_align.sv
module bytestore_align #(
  parameter int ADDR_W = 32,
  parameter int LANES  = 4,
  localparam int DW    = 8 * LANES,
  localparam int OFS_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_head,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_value,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DW-1:0]     wr_data,
  output logic [LANES-1:0]  wr_be,
  output logic              wr_probe
);
  bsa_pkg::fill_mode_e mode;
  logic [OFS_W-1:0]    ofs;
  logic [LANES-1:0]    be_c;
  logic                probe_c;
  logic [DW-1:0]       data_c;
  logic [ADDR_W-1:0]   waddr_c;
  logic                accept;

  assign mode    = req_head ? bsa_pkg::FILL_HEAD : bsa_pkg::FILL_TAIL;
  assign ofs     = req_addr[OFS_W-1:0];
  assign waddr_c = {req_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
  assign req_ready = !wr_valid || wr_ready;
  assign accept  = req_valid && req_ready;

  bsa_lane_mask #(.LANES(LANES)) u_mask (
    .mode(mode), .ofs(ofs), .be(be_c), .probe(probe_c));

  bsa_lane_steer #(.LANES(LANES)) u_steer (
    .value(req_value), .be(be_c), .data(data_c));

  bsa_out_reg #(.ADDR_W(ADDR_W), .LANES(LANES)) u_oreg (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .n_addr(waddr_c), .n_data(data_c), .n_be(be_c), .n_probe(probe_c),
    .q_valid(wr_valid), .q_ready(wr_ready),
    .q_addr(wr_addr), .q_data(wr_data), .q_be(wr_be), .q_probe(wr_probe));

  p_addr_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_addr[OFS_W-1:0] == '0);

  p_probe_no_be_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_probe |-> wr_be == '0);

  p_be_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_probe |-> wr_be != '0);

  p_three_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept && $countones(be_c) == LANES - 1 |=> wr_be == $past(be_c));

  p_disabled_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_be == '0 |-> wr_data == '0);
endmodule

// File: tb/sim_bytestore_align.sv
module sim_bytestore_align;
  localparam int CLK_NS = 10;
  localparam int AW = 12;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_head = 0, wr_ready = 0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_value = '0;
  logic req_ready, wr_valid, wr_probe;
  logic [AW-1:0] wr_addr;
  logic [31:0] wr_data;
  logic [3:0] wr_be;

  always #(CLK_NS/2) clk = ~clk;

  bytestore_align #(.ADDR_W(AW), .LANES(4)) u0 (.*);

  int checks = 0, errors = 0, reqs = 0, beats = 0;
  logic [AW+36:0] q[$]; // {probe, be, data, addr}

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW+36:0] model(bit head, logic [AW-1:0] a, logic [31:0] v);
    int o = a % 4;
    logic [3:0] be;
    logic [31:0] d;
    if (!head) be = 4'((1 << (4 - o)) - 1);
    else be = (o == 0) ? 4'b0000 : 4'(~((1 << (4 - o)) - 1));
    d = 0;
    for (int k = 0; k < 4; k++) if (be[k]) d[8*k +: 8] = v[8*k +: 8];
    return {(head && o == 0), be, d, AW'((a / 4) * 4)};
  endfunction

  function automatic string be_tag(bit head, int o);
    if (head) return (o == 0) ? "R6" : "R5";
    return (o == 0) ? "R3" : "R4";
  endfunction

  // reference model: compared at every negedge, updated at every posedge
  logic [AW+36:0] head_e;
  bit exp_rdy, acc, pop;
  string cur_tag = "R3";
  int stall_len = 0;
  logic [AW+36:0] held;

  task automatic compare();
    chk(req_ready === exp_rdy, "R9 req_ready", req_ready, exp_rdy);
    chk(wr_valid === (q.size() != 0), "R8 wr_valid", wr_valid, q.size() != 0);
    if (q.size() != 0 && wr_valid) begin
      head_e = q[0];
      chk(wr_addr === head_e[AW-1:0], "R2 addr", wr_addr, head_e[AW-1:0]);
      chk(wr_be === head_e[AW+35:AW+32], {be_tag(head_e[AW+36] | (head_e[AW+35:AW+32] != 4'hF && head_e[AW+32] == 1'b0 && head_e[AW+35]), 0), "/R4/R5 be"},
          wr_be, head_e[AW+35:AW+32]);
      chk(wr_data === head_e[AW+31:AW], "R7 data", wr_data, head_e[AW+31:AW]);
      chk(wr_probe === head_e[AW+36], head_e[AW+36] ? "R6 probe" : "R10 probe", wr_probe, head_e[AW+36]);
    end
  endtask

  task automatic step(bit v, bit h, logic [AW-1:0] a, logic [31:0] val, bit rdy);
    @(negedge clk);
    exp_rdy = (q.size() == 0) || wr_ready;
    compare();
    if (wr_valid && !wr_ready) begin
      if (stall_len > 0) chk({wr_addr, wr_data, wr_be, wr_probe} === held, "R9 stable", 0, 1);
      held = {wr_addr, wr_data, wr_be, wr_probe};
      stall_len++;
    end else stall_len = 0;
    req_valid = v; req_head = h; req_addr = a; req_value = val; wr_ready = rdy;
    exp_rdy = (q.size() == 0) || rdy;
    acc = v && exp_rdy;
    pop = (q.size() != 0) && rdy;
    @(posedge clk);
    if (pop) begin void'(q.pop_front()); beats++; end
    if (acc) begin q.push_back(model(h, a, val)); reqs++; end
  endtask

  initial begin
    #(CLK_NS * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(wr_valid === 1'b0, "R1 wr_valid", wr_valid, 0);
    chk(req_ready === 1'b1, "R1 req_ready", req_ready, 1);
    rst_n = 1;
    // directed: every mode/offset, ready held high (R3 R4 R5 R6 R8)
    for (int h = 0; h < 2; h++)
      for (int o = 0; o < 4; o++)
        step(1, h[0], AW'(12'h3A0 + o), 32'hA1B2C3D4, 1);
    // directed back-pressure on three-byte and probe beats (R8 R9)
    step(1, 0, 12'h101, 32'h11223344, 0);
    step(1, 1, 12'h203, 32'h55667788, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1);
    step(1, 1, 12'h204, 32'h99AABBCC, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1);
    // random traffic with throttled ready
    for (int n = 0; n < 3000; n++)
      step($urandom_range(0, 3) != 0, 1'($urandom), AW'($urandom), $urandom,
           $urandom_range(0, 2) != 0);
    while (q.size() != 0) step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 1);
    chk(beats == reqs, "R8 one beat per request", beats, reqs);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule